// File: doc/BRIEF.md
# GPIO Bank Register Block with Masked Half-Word Writes

This block holds the register state for one 32-pin general-purpose I/O bank behind a simple memory-mapped bus (address, write data, write strobe, read strobe, read data). It keeps the output value of every pin, a per-pin direction bit and a per-pin output-enable bit. It also lets software read the sampled level of every pin. The pad drivers and the input synchronizer sit outside. The block receives already-synchronized pin levels and drives a value and an enable for each pin.

Software can change individual output pins without a read-modify-write sequence. Two half-word write ports each carry a 16-bit protect mask in the upper half of the bus word and 16 data bits in the lower half. Only the unprotected bits of the addressed half of the output register change, so each write is atomic. The bank index is a parameter, and every register address is derived from it.

Top module: `gpmw_bank`

## Requirements
- R1: After reset the output data, direction and output-enable registers are all 0, so `pin_out` and `pin_oe` are 0 and the read data is 0.
- R2: A write to the low masked port (address 8×bank) uses `bus_wdata[31:16]` as a protect mask for output bits 15:0. Where a mask bit is 0, the output bit takes `bus_wdata[i]`. Where it is 1, the output bit keeps its value. Output bits 31:16 are untouched.
- R3: A write to the high masked port (address 8×bank+4) applies the same rule to output bits 31:16, with data from `bus_wdata[15:0]` and mask from `bus_wdata[31:16]`. Output bits 15:0 are untouched.
- R4: The full data register (address 0x40+4×bank) is read/write. A write replaces all 32 output bits, and a read returns them.
- R5: The pin-level register (address 0x60+4×bank) returns `pin_in` as it was sampled at the read strobe, for every pin, whatever its direction. Writes to it change nothing.
- R6: The direction register (address 0x204+0x40×bank) is read/write. Bit value 1 selects output and bit value 0 selects input.
- R7: The output-enable register (address 0x208+0x40×bank) is read/write. `pin_oe[i]` is 1 only when both direction bit i and output-enable bit i are 1.
- R8: A read of either masked port returns the matching half of the output data in bits 15:0 and 0 in bits 31:16.
- R9: Read data appears on `bus_rdata` in the cycle after the read strobe. A read of an unmapped address returns 0, and a write to an unmapped address changes no register.
- R10: A register write takes effect on `pin_out` and `pin_oe` at the clock edge that samples the write strobe. Without a write strobe both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | 32 | Synchronized pin levels |
| pin_out | output | 32 | Output value for each pin |
| pin_oe | output | 32 | Drive enable for each pin |

## Verification
The hardest case to reach is a masked write whose mask is only partly set over an output half that already holds a mixed pattern. Only then does a protected bit differ from the bit that the data field would have loaded. The stimulus first loads random full-width values through the data register. It then interleaves masked writes with random masks and data on both halves. Directed cases cover the all-protect mask, the no-protect mask, writes to the pin-level register and writes to an unmapped address.

// File: rtl/gpmw_pkg.sv
package gpmw_pkg;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_LO   = 3'd1,
      SEL_HI   = 3'd2,
      SEL_DATA = 3'd3,
      SEL_PIN  = 3'd4,
      SEL_DIR  = 3'd5,
      SEL_OE   = 3'd6
   } reg_sel_e;

   // byte offsets of each register for a given bank index
   function automatic int unsigned off_lo(int unsigned b);
      return 8 * b;
   endfunction
   function automatic int unsigned off_hi(int unsigned b);
      return 8 * b + 4;
   endfunction
   function automatic int unsigned off_data(int unsigned b);
      return 32'h40 + 4 * b;
   endfunction
   function automatic int unsigned off_pin(int unsigned b);
      return 32'h60 + 4 * b;
   endfunction
   function automatic int unsigned off_dir(int unsigned b);
      return 32'h204 + 32'h40 * b;
   endfunction
   function automatic int unsigned off_oe(int unsigned b);
      return 32'h208 + 32'h40 * b;
   endfunction

endpackage

// File: rtl/gpmw_decode.sv
module gpmw_decode
   import gpmw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned BANK_IDX = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(off_lo(BANK_IDX));
   localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(off_hi(BANK_IDX));
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(off_data(BANK_IDX));
   localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(off_pin(BANK_IDX));
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(off_dir(BANK_IDX));
   localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(off_oe(BANK_IDX));

   always_comb begin
      unique case (addr)
         A_LO:    sel = SEL_LO;
         A_HI:    sel = SEL_HI;
         A_DATA:  sel = SEL_DATA;
         A_PIN:   sel = SEL_PIN;
         A_DIR:   sel = SEL_DIR;
         A_OE:    sel = SEL_OE;
         default: sel = SEL_NONE;
      endcase
   end
endmodule

// File: rtl/gpmw_regs.sv
module gpmw_regs
   import gpmw_pkg::*;
#(
   parameter int unsigned HALF_W = 16,
   localparam int unsigned PINS  = 2 * HALF_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  reg_sel_e        sel,
   input  logic [PINS-1:0] wdata,
   output logic [PINS-1:0] data_q,
   output logic [PINS-1:0] dir_q,
   output logic [PINS-1:0] oe_q
);
   localparam int unsigned NHALF = 2;

   logic [PINS-1:0]  merged;
   logic [NHALF-1:0] half_hit;
   logic [PINS-1:0]  data_d;

   // per-half protected merge: mask bit 1 keeps, 0 loads
   for (genvar h = 0; h < NHALF; h++) begin : g_half
      localparam reg_sel_e HSEL = (h == 0) ? SEL_LO : SEL_HI;
      assign merged[h*HALF_W +: HALF_W] =
         (data_q[h*HALF_W +: HALF_W] & wdata[PINS-1:HALF_W]) |
         (wdata[HALF_W-1:0] & ~wdata[PINS-1:HALF_W]);
      assign half_hit[h] = wr && (sel == HSEL);
   end

   always_comb begin
      data_d = data_q;
      if (wr && sel == SEL_DATA) data_d = wdata;
      for (int h = 0; h < NHALF; h++) begin
         if (half_hit[h]) data_d[h*HALF_W +: HALF_W] = merged[h*HALF_W +: HALF_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         oe_q   <= '0;
      end else begin
         data_q <= data_d;
         if (wr && sel == SEL_DIR) dir_q <= wdata;
         if (wr && sel == SEL_OE)  oe_q  <= wdata;
      end
   end
endmodule

// File: rtl/gpmw_rdmux.sv
module gpmw_rdmux
   import gpmw_pkg::*;
#(
   parameter int unsigned HALF_W = 16,
   localparam int unsigned PINS  = 2 * HALF_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd,
   input  reg_sel_e        sel,
   input  logic [PINS-1:0] data_q,
   input  logic [PINS-1:0] dir_q,
   input  logic [PINS-1:0] oe_q,
   input  logic [PINS-1:0] pin_lvl,
   output logic [PINS-1:0] rdata
);
   logic [PINS-1:0] rsel;

   always_comb begin
      unique case (sel)
         SEL_LO:   rsel = {{HALF_W{1'b0}}, data_q[HALF_W-1:0]};
         SEL_HI:   rsel = {{HALF_W{1'b0}}, data_q[PINS-1:HALF_W]};
         SEL_DATA: rsel = data_q;
         SEL_PIN:  rsel = pin_lvl;
         SEL_DIR:  rsel = dir_q;
         SEL_OE:   rsel = oe_q;
         default:  rsel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= rsel;
   end
endmodule

// File: rtl/gpmw_bank.sv
module gpmw_bank
   import gpmw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned HALF_W   = 16,
   parameter int unsigned BANK_IDX = 0,
   localparam int unsigned PINS    = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [PINS-1:0]   bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [PINS-1:0]   bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe
);
   localparam int unsigned TOP_OFF = off_oe(BANK_IDX);

   if (HALF_W != 16) begin : g_bad_half
      $error("gpmw_bank: the mask/data word layout needs HALF_W == 16");
   end
   if (BANK_IDX > 7) begin : g_bad_bank
      $error("gpmw_bank: BANK_IDX above 7 collides masked and full-data addresses");
   end
   if (TOP_OFF >= (1 << ADDR_W)) begin : g_bad_addr
      $error("gpmw_bank: ADDR_W too narrow for this bank's offsets");
   end

   reg_sel_e        sel;
   logic [PINS-1:0] data_q, dir_q, oe_q;

   gpmw_decode #(.ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   gpmw_regs #(.HALF_W(HALF_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr),
      .sel    (sel),
      .wdata  (bus_wdata),
      .data_q (data_q),
      .dir_q  (dir_q),
      .oe_q   (oe_q)
   );

   gpmw_rdmux #(.HALF_W(HALF_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd      (bus_rd),
      .sel     (sel),
      .data_q  (data_q),
      .dir_q   (dir_q),
      .oe_q    (oe_q),
      .pin_lvl (pin_in),
      .rdata   (bus_rdata)
   );

   assign pin_out = data_q;
   assign pin_oe  = dir_q & oe_q;
endmodule

// File: rtl/gpmw_bank_chk.sv
module gpmw_bank_chk
   import gpmw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned HALF_W   = 16,
   parameter int unsigned BANK_IDX = 0,
   localparam int unsigned PINS    = 2 * HALF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [PINS-1:0]   bus_wdata,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [PINS-1:0]   bus_rdata,
   input logic [PINS-1:0]   pin_in,
   input logic [PINS-1:0]   pin_out,
   input logic [PINS-1:0]   pin_oe
);
   localparam logic [ADDR_W-1:0] C_LO  = ADDR_W'(off_lo(BANK_IDX));
   localparam logic [ADDR_W-1:0] C_HI  = ADDR_W'(off_hi(BANK_IDX));
   localparam logic [ADDR_W-1:0] C_PIN = ADDR_W'(off_pin(BANK_IDX));
   localparam logic [ADDR_W-1:0] C_DIR = ADDR_W'(off_dir(BANK_IDX));

   // R2: protected low bits hold, unprotected low bits load, high half holds
   a_r2_lo_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == C_LO) |=>
         ((pin_out[HALF_W-1:0] ^ $past(pin_out[HALF_W-1:0])) & $past(bus_wdata[PINS-1:HALF_W])) == '0);
   a_r2_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == C_LO) |=>
         ((pin_out[HALF_W-1:0] ^ $past(bus_wdata[HALF_W-1:0])) & ~$past(bus_wdata[PINS-1:HALF_W])) == '0);
   a_r2_lo_other: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == C_LO) |=> $stable(pin_out[PINS-1:HALF_W]));

   // R3: same rule on the high half
   a_r3_hi_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == C_HI) |=>
         ((pin_out[PINS-1:HALF_W] ^ $past(pin_out[PINS-1:HALF_W])) & $past(bus_wdata[PINS-1:HALF_W])) == '0);
   a_r3_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == C_HI) |=>
         ((pin_out[PINS-1:HALF_W] ^ $past(bus_wdata[HALF_W-1:0])) & ~$past(bus_wdata[PINS-1:HALF_W])) == '0);
   a_r3_hi_other: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == C_HI) |=> $stable(pin_out[HALF_W-1:0]));

   // R5: pin-level read returns the sampled pins
   a_r5_pin_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == C_PIN) |=> bus_rdata == $past(pin_in));

   // R7: clearing all direction bits removes every drive enable
   a_r7_dir_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == C_DIR && bus_wdata == '0) |=> pin_oe == '0);

   // R10: no write strobe, no output change
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));

   // R9: no read strobe, read data holds
   a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpmw_bank gpmw_bank_chk #(
   .ADDR_W(ADDR_W), .HALF_W(HALF_W), .BANK_IDX(BANK_IDX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/gpmw_bank_tb.sv
module gpmw_bank_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 12;
   localparam int BANK       = 1;

   localparam logic [ADDR_W-1:0] AD_LO   = ADDR_W'(8 * BANK);
   localparam logic [ADDR_W-1:0] AD_HI   = ADDR_W'(8 * BANK + 4);
   localparam logic [ADDR_W-1:0] AD_DATA = ADDR_W'(32'h40 + 4 * BANK);
   localparam logic [ADDR_W-1:0] AD_PIN  = ADDR_W'(32'h60 + 4 * BANK);
   localparam logic [ADDR_W-1:0] AD_DIR  = ADDR_W'(32'h204 + 32'h40 * BANK);
   localparam logic [ADDR_W-1:0] AD_OE   = ADDR_W'(32'h208 + 32'h40 * BANK);
   localparam logic [ADDR_W-1:0] AD_NONE = ADDR_W'(32'h100);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [31:0]       bus_rdata;
   logic [31:0]       pin_in = '0;
   logic [31:0]       pin_out;
   logic [31:0]       pin_oe;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] m_data = '0, m_dir = '0, m_oe = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpmw_bank #(.ADDR_W(ADDR_W), .HALF_W(16), .BANK_IDX(BANK)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   function automatic logic [15:0] mmerge(logic [15:0] cur, logic [31:0] w);
      return (cur & w[31:16]) | (w[15:0] & ~w[31:16]);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      // bench model of the register file
      if (a == AD_LO)   m_data[15:0]  = mmerge(m_data[15:0], d);
      if (a == AD_HI)   m_data[31:16] = mmerge(m_data[31:16], d);
      if (a == AD_DATA) m_data = d;
      if (a == AD_DIR)  m_dir = d;
      if (a == AD_OE)   m_oe = d;
   endtask

   task automatic bus_read(logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic check_pins(string req);
      check({req, " pin_out"}, pin_out, m_data);
      check({req, " pin_oe"}, pin_oe, m_dir & m_oe);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] rd_v, pv, snap;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 pin_out", pin_out, 32'h0);
      check("R1 pin_oe", pin_oe, 32'h0);
      check("R1 rdata", bus_rdata, 32'h0);
      bus_read(AD_DATA, rd_v); check("R1 data", rd_v, 32'h0);
      bus_read(AD_DIR, rd_v);  check("R1 dir", rd_v, 32'h0);
      bus_read(AD_OE, rd_v);   check("R1 oe", rd_v, 32'h0);

      // R4 / R10: full write visible on pins right after the write edge
      bus_write(AD_DATA, 32'hA5A5_0F0F); check_pins("R4 R10");
      bus_read(AD_DATA, rd_v); check("R4 readback", rd_v, 32'hA5A5_0F0F);

      // R2: partial mask on low half
      bus_write(AD_LO, 32'hFF00_00AB); check_pins("R2 partial");
      check("R2 value", pin_out, 32'hA5A5_0FAB);
      // R2: all-protect mask changes nothing
      bus_write(AD_LO, 32'hFFFF_1234); check("R2 all-protect", pin_out, 32'hA5A5_0FAB);
      // R3: no-protect mask loads whole high half
      bus_write(AD_HI, 32'h0000_1234); check("R3 no-protect", pin_out, 32'h1234_0FAB);
      bus_write(AD_HI, 32'h00FF_FF00); check("R3 partial", pin_out, 32'hFF34_0FAB);

      // R8: masked-port reads
      bus_read(AD_LO, rd_v); check("R8 low", rd_v, 32'h0000_0FAB);
      bus_read(AD_HI, rd_v); check("R8 high", rd_v, 32'h0000_FF34);

      // R6 / R7: direction and output enable gating
      bus_write(AD_DIR, 32'h0000_FFFF);
      bus_write(AD_OE, 32'h00FF_00FF); check("R7 gate", pin_oe, 32'h0000_00FF);
      bus_read(AD_DIR, rd_v); check("R6 readback", rd_v, 32'h0000_FFFF);
      bus_read(AD_OE, rd_v);  check("R7 readback", rd_v, 32'h00FF_00FF);

      // R5: pin levels regardless of direction; writes ignored
      pin_in = 32'hDEAD_BEEF;
      bus_read(AD_PIN, rd_v); check("R5 level", rd_v, 32'hDEAD_BEEF);
      snap = pin_out;
      bus_write(AD_PIN, 32'h1111_2222);
      check("R5 write ignored", pin_out, snap);
      bus_read(AD_PIN, rd_v); check("R5 still level", rd_v, 32'hDEAD_BEEF);

      // R9: unmapped address
      bus_write(AD_NONE, 32'hFFFF_FFFF); check_pins("R9 unmapped write");
      bus_read(AD_NONE, rd_v); check("R9 unmapped read", rd_v, 32'h0);

      // random mix
      for (int i = 0; i < 600; i++) begin
         int op;
         logic [31:0] w;
         op = int'($urandom_range(0, 6));
         w = $urandom();
         pin_in = $urandom();
         case (op)
            0: begin bus_write(AD_LO, w);   check_pins("R2 random"); end
            1: begin bus_write(AD_HI, w);   check_pins("R3 random"); end
            2: begin bus_write(AD_DATA, w); check_pins("R4 random"); end
            3: begin bus_write(AD_DIR, w);  check_pins("R6 random"); end
            4: begin bus_write(AD_OE, w);   check_pins("R7 random"); end
            5: begin
               pv = pin_in;
               bus_read(AD_PIN, rd_v); check("R5 random", rd_v, pv);
            end
            default: begin
               bus_read(AD_DATA, rd_v); check("R4 random read", rd_v, m_data);
               bus_read(AD_LO, rd_v);   check("R8 random low", rd_v, {16'h0, m_data[15:0]});
               bus_read(AD_HI, rd_v);   check("R8 random high", rd_v, {16'h0, m_data[31:16]});
            end
         endcase
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule